// File: doc/BRIEF.md
# Double-Buffered TDM Slot Route Table

This block stores the per-slot routing entries that a time-division-multiplexed serial sequencer steps through. The table is divided into an active half and a shadow half for every receive and transmit route. Software can therefore prepare a new routing plan while traffic keeps flowing. The host may read any entry. Host writes are accepted only when they land in a shadow half. When software sets a per-TDM swap request, the block exchanges the two halves on that TDM's next frame sync and clears the request in hardware at the same clock edge.

Two layouts are supported, selected by `dual_i`:
- **Single-TDM layout.** One TDM owns a quarter of the table for receive and a quarter for transmit.
- **Dual-TDM layout.** Each of two TDMs owns an eighth of the table per direction.

For each of four routes (receive A, receive B, transmit A, transmit B), a pointer walks the active region. The block presents the pointer's absolute address and the entry stored there to the sequencer. The sequencer pulses an advance input when it has finished the current entry.

Top module: `tdm_route_dbuf`

## Requirements
- R1: In the single-TDM layout (`dual_i`=0), the regions have size DEPTH/4. The base of route A in direction d (0 receive, 1 transmit) with active half h is d·DEPTH/2 + h·DEPTH/4. The route B outputs are 0, TDM B has no effect, and `active_half_o[1]` and `swap_pend_o[1]` read 0.
- R2: In the dual-TDM layout, the regions have size DEPTH/8. The base of route (d,t) is d·DEPTH/2 + t·DEPTH/4 + h_t·DEPTH/8, where t is 0 for TDM A and 1 for TDM B, and h_t is that TDM's active half.
- R3: After reset:
  - both active halves are 0;
  - both swap requests are clear;
  - the write-error flag is clear;
  - every route pointer sits at its region base.
- R4: `tbl_rdata_o` returns the entry at the `tbl_addr_i` value presented one clock earlier, for any address.
- R5: A host write to a shadow half is stored. A host write to an active half leaves the table unchanged and sets `wr_err_o` at the next edge. In the dual layout, address bit AW-2 selects the TDM and bit AW-3 selects the half. In the single layout, bit AW-2 selects the half.
- R6: `wr_err_o` stays set until a control write with bit 2 set. A blocked write in the same cycle as the clear leaves the flag set.
- R7: A control write with bit t set raises `swap_pend_o[t]`. At the next `sync_i[t]`, that TDM's active half toggles and the request clears at the same edge. In the single layout, bit 1 is ignored.
- R8: A frame sync with no pending request leaves the active half unchanged.
- R9: An advance pulse moves a route's pointer to the next entry. The pointer returns to the region base after an entry whose bit 0 (last flag) is 1, or after the final entry of the region.
- R10: A frame sync returns the pointers of that TDM's routes to the base of the half that is active after any swap. A sync takes priority over an advance in the same cycle.
- R11: Changing `dual_i` does all of the following:
  - returns both active halves to 0;
  - clears both swap requests;
  - returns all pointers to their bases;
  - drops a table write presented in the same cycle, without flagging an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dual_i | input | 1 | Layout select: 0 single TDM, 1 two TDMs |
| sync_i | input | 2 | Frame sync pulse per TDM (bit 0 A, bit 1 B) |
| adv_i | input | 4 | Advance per route: {tx B, tx A, rx B, rx A} |
| tbl_we_i | input | 1 | Host table write strobe |
| tbl_addr_i | input | AW | Host table address (read and write) |
| tbl_wdata_i | input | DATA_W | Host write data |
| tbl_rdata_o | output | DATA_W | Host read data, one cycle latency |
| csr_we_i | input | 1 | Control write strobe |
| csr_wdata_i | input | 3 | Bits 1:0 set swap request per TDM; bit 2 clears the write error |
| active_half_o | output | 2 | Active half per TDM |
| swap_pend_o | output | 2 | Pending swap request per TDM |
| wr_err_o | output | 1 | Sticky blocked-write flag |
| route_addr_o | output | 4·AW | Current absolute address per route, route r at bits r·AW |
| route_entry_o | output | 4·DATA_W | Entry at each route's current address |

## Verification
The assertions check several relationships on every clock edge:
- a pending request plus a sync toggles the active half and clears the request;
- the active half is otherwise stable;
- a write aimed at the active half raises the error flag, and the flag persists until cleared;
- a sync puts route A back on the base of its current half;
- a layout change clears the swap state.

Only the bench's scenarios can show that a blocked write really left the stored contents intact, or that reads return what the shadow writes stored. The same holds for the walk of a pointer through a full region and its early return on a last flag, the dropped write at a layout change, and the full address sweeps in both layouts.

// File: rtl/tdm_rt_pkg.sv
package tdm_rt_pkg;

  localparam int unsigned NROUTE = 4;

  // Absolute base of a route region for a given layout and active half.
  function automatic int unsigned rt_base(int unsigned depth, logic dual,
                                          logic dir, logic tdm, logic half);
    int unsigned b;
    b = dir ? depth / 2 : 0;
    if (dual) begin
      b = b + (tdm ? depth / 4 : 0) + (half ? depth / 8 : 0);
    end else begin
      b = b + (half ? depth / 4 : 0);
    end
    return b;
  endfunction

  // Number of entries in one route region.
  function automatic int unsigned rt_size(int unsigned depth, logic dual);
    return dual ? depth / 8 : depth / 4;
  endfunction

endpackage

// File: rtl/tdm_rt_ctrl.sv
module tdm_rt_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dual_i,
  input  logic [1:0] sync_i,
  input  logic       csr_we_i,
  input  logic [2:0] csr_wdata_i,
  input  logic       blocked_i,
  output logic       mode_q_o,
  output logic       mode_chg_o,
  output logic [1:0] half_q_o,
  output logic [1:0] pend_q_o,
  output logic       err_q_o
);

  logic       mode_q;
  logic [1:0] half_q, half_d;
  logic [1:0] pend_q, pend_d;
  logic       err_q, err_d;
  logic [1:0] tdm_en;
  logic [1:0] swap_now;
  logic [1:0] req_set;
  logic       mode_chg;

  assign mode_chg = dual_i ^ mode_q;
  assign tdm_en   = {mode_q, 1'b1};
  assign swap_now = pend_q & sync_i & tdm_en;
  assign req_set  = csr_we_i ? (csr_wdata_i[1:0] & tdm_en) : 2'b00;

  always_comb begin
    if (mode_chg) begin
      half_d = 2'b00;
      pend_d = 2'b00;
    end else begin
      half_d = half_q ^ swap_now;
      pend_d = (pend_q & ~(sync_i & tdm_en)) | req_set;
    end
  end

  always_comb begin
    err_d = err_q;
    if (csr_we_i && csr_wdata_i[2]) begin
      err_d = 1'b0;
    end
    if (blocked_i) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      half_q <= 2'b00;
      pend_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      mode_q <= dual_i;
      half_q <= half_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign mode_q_o   = mode_q;
  assign mode_chg_o = mode_chg;
  assign half_q_o   = half_q;
  assign pend_q_o   = pend_q;
  assign err_q_o    = err_q;

endmodule

// File: rtl/tdm_rt_mem.sv
module tdm_rt_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NR    = tdm_rt_pkg::NROUTE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_q_i,
  input  logic                 mode_chg_i,
  input  logic [1:0]           half_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 blocked_o,
  input  logic [NR*AW-1:0]     raddr_i,
  output logic [NR*DATA_W-1:0] rentry_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              hits_active;
  logic              wr_ok;

  // Decode whether the host address falls in a currently active half.
  always_comb begin
    if (mode_q_i) begin
      hits_active = (addr_i[AW-3] == half_i[addr_i[AW-2]]);
    end else begin
      hits_active = (addr_i[AW-2] == half_i[0]);
    end
  end

  assign wr_ok     = we_i & ~mode_chg_i & ~hits_active;
  assign blocked_o = we_i & ~mode_chg_i &  hits_active;

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

  for (genvar r = 0; r < NR; r++) begin : g_rport
    assign rentry_o[r*DATA_W +: DATA_W] = mem_q[raddr_i[r*AW +: AW]];
  end

endmodule

// File: rtl/tdm_rt_ptr.sv
module tdm_rt_ptr #(
  parameter int unsigned DEPTH = 256,
  parameter bit          DIR   = 1'b0,
  parameter bit          TDM   = 1'b0,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_q_i,
  input  logic          mode_chg_i,
  input  logic          half_i,
  input  logic          sync_i,
  input  logic          adv_i,
  input  logic          last_i,
  output logic          en_o,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] off_q, off_d;
  logic [AW-1:0] base;
  logic [AW-1:0] size_m1;
  logic          en;

  assign en      = !TDM || mode_q_i;
  assign base    = AW'(tdm_rt_pkg::rt_base(DEPTH, mode_q_i, DIR, TDM, half_i));
  assign size_m1 = AW'(tdm_rt_pkg::rt_size(DEPTH, mode_q_i) - 1);

  always_comb begin
    off_d = off_q;
    if (mode_chg_i || !en || sync_i) begin
      off_d = '0;
    end else if (adv_i) begin
      if (last_i || (off_q == size_m1)) begin
        off_d = '0;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
    end else begin
      off_q <= off_d;
    end
  end

  assign en_o   = en;
  assign addr_o = en ? (base + off_q) : '0;

endmodule

// File: rtl/tdm_route_dbuf.sv
module tdm_route_dbuf #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NR    = tdm_rt_pkg::NROUTE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dual_i,
  input  logic [1:0]           sync_i,
  input  logic [NR-1:0]        adv_i,
  input  logic                 tbl_we_i,
  input  logic [AW-1:0]        tbl_addr_i,
  input  logic [DATA_W-1:0]    tbl_wdata_i,
  output logic [DATA_W-1:0]    tbl_rdata_o,
  input  logic                 csr_we_i,
  input  logic [2:0]           csr_wdata_i,
  output logic [1:0]           active_half_o,
  output logic [1:0]           swap_pend_o,
  output logic                 wr_err_o,
  output logic [NR*AW-1:0]     route_addr_o,
  output logic [NR*DATA_W-1:0] route_entry_o
);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_sync;
  logic                 mode_q;
  logic                 mode_chg;
  logic [1:0]           half_q;
  logic                 blocked;
  logic [NR*AW-1:0]     raddr;
  logic [NR*DATA_W-1:0] rentry;
  logic [NR-1:0]        route_en;

  // Reset asserts asynchronously, releases on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  tdm_rt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .dual_i     (dual_i),
    .sync_i     (sync_i),
    .csr_we_i   (csr_we_i),
    .csr_wdata_i(csr_wdata_i),
    .blocked_i  (blocked),
    .mode_q_o   (mode_q),
    .mode_chg_o (mode_chg),
    .half_q_o   (half_q),
    .pend_q_o   (swap_pend_o),
    .err_q_o    (wr_err_o)
  );

  tdm_rt_mem #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .mode_q_i  (mode_q),
    .mode_chg_i(mode_chg),
    .half_i    (half_q),
    .we_i      (tbl_we_i),
    .addr_i    (tbl_addr_i),
    .wdata_i   (tbl_wdata_i),
    .rdata_o   (tbl_rdata_o),
    .blocked_o (blocked),
    .raddr_i   (raddr),
    .rentry_o  (rentry)
  );

  for (genvar r = 0; r < NR; r++) begin : g_route
    tdm_rt_ptr #(
      .DEPTH(DEPTH),
      .DIR  (bit'(r / 2)),
      .TDM  (bit'(r % 2))
    ) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_sync),
      .mode_q_i  (mode_q),
      .mode_chg_i(mode_chg),
      .half_i    (half_q[r % 2]),
      .sync_i    (sync_i[r % 2]),
      .adv_i     (adv_i[r]),
      .last_i    (rentry[r*DATA_W]),
      .en_o      (route_en[r]),
      .addr_o    (raddr[r*AW +: AW])
    );
    assign route_entry_o[r*DATA_W +: DATA_W] =
      route_en[r] ? rentry[r*DATA_W +: DATA_W] : '0;
  end

  assign route_addr_o  = raddr;
  assign active_half_o = half_q;

endmodule

// File: rtl/tdm_route_dbuf_chk.sv
module tdm_route_dbuf_chk #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NR    = tdm_rt_pkg::NROUTE
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             mode_q,
  input logic             mode_chg,
  input logic [1:0]       sync_i,
  input logic             tbl_we_i,
  input logic [AW-1:0]    tbl_addr_i,
  input logic             csr_we_i,
  input logic [2:0]       csr_wdata_i,
  input logic [1:0]       active_half_o,
  input logic [1:0]       swap_pend_o,
  input logic             wr_err_o,
  input logic [NR*AW-1:0] route_addr_o
);

  logic in_active;
  logic [AW-1:0] rxa_base;

  always_comb begin
    if (mode_q) begin
      in_active = (tbl_addr_i[AW-3] == active_half_o[tbl_addr_i[AW-2]]);
    end else begin
      in_active = (tbl_addr_i[AW-2] == active_half_o[0]);
    end
  end

  assign rxa_base = AW'(tdm_rt_pkg::rt_base(DEPTH, mode_q, 1'b0, 1'b0, active_half_o[0]));

  a_r7_swap_toggles: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_chg && swap_pend_o[0] && sync_i[0])
      |=> (active_half_o[0] != $past(active_half_o[0])));

  a_r7_request_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_chg && swap_pend_o[0] && sync_i[0] && !(csr_we_i && csr_wdata_i[0]))
      |=> !swap_pend_o[0]);

  a_r8_half_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_chg && !(swap_pend_o[0] && sync_i[0])) |=> $stable(active_half_o[0]));

  a_r1_b_idle_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mode_q |-> (!active_half_o[1] && !swap_pend_o[1] && route_addr_o[AW +: AW] == '0));

  a_r5_block_flags: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tbl_we_i && !mode_chg && in_active) |=> wr_err_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_err_o && !(csr_we_i && csr_wdata_i[2])) |=> wr_err_o);

  a_r10_sync_to_base: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_chg && sync_i[0]) |=> (route_addr_o[0 +: AW] == rxa_base));

  a_r11_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_chg |=> (active_half_o == 2'b00 && swap_pend_o == 2'b00));

endmodule

bind tdm_route_dbuf tdm_route_dbuf_chk #(
  .DEPTH (DEPTH),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .mode_q       (mode_q),
  .mode_chg     (mode_chg),
  .sync_i       (sync_i),
  .tbl_we_i     (tbl_we_i),
  .tbl_addr_i   (tbl_addr_i),
  .csr_we_i     (csr_we_i),
  .csr_wdata_i  (csr_wdata_i),
  .active_half_o(active_half_o),
  .swap_pend_o  (swap_pend_o),
  .wr_err_o     (wr_err_o),
  .route_addr_o (route_addr_o)
);

// File: tb/tb_tdm_route_dbuf.sv
module tb_tdm_route_dbuf;

  localparam int DEPTH = 256;
  localparam int DW    = 8;
  localparam int AW    = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          dual_i;
  logic [1:0]    sync_i;
  logic [3:0]    adv_i;
  logic          tbl_we_i;
  logic [AW-1:0] tbl_addr_i;
  logic [DW-1:0] tbl_wdata_i;
  logic [DW-1:0] tbl_rdata_o;
  logic          csr_we_i;
  logic [2:0]    csr_wdata_i;
  logic [1:0]    active_half_o;
  logic [1:0]    swap_pend_o;
  logic          wr_err_o;
  logic [4*AW-1:0] route_addr_o;
  logic [4*DW-1:0] route_entry_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  logic [DW-1:0] mdl   [DEPTH];
  bit            known [DEPTH];
  bit            dual_m;
  bit [1:0]      half_m;

  always #2 clk_i = ~clk_i;

  tdm_route_dbuf dut (.*);

  function automatic logic [DW-1:0] dat(int a, int g);
    return DW'(((a * 3 + g * 101) * 2) & 8'hFE);
  endfunction

  function automatic bit is_act(int a);
    if (dual_m) return (((a >> 5) & 1) == half_m[(a >> 6) & 1]);
    return (((a >> 6) & 1) == half_m[0]);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  function automatic int raddr(int r);
    return int'(route_addr_o[r*AW +: AW]);
  endfunction

  function automatic int rent(int r);
    return int'(route_entry_o[r*DW +: DW]);
  endfunction

  task automatic csr(int v);
    csr_we_i = 1'b1;
    csr_wdata_i = 3'(v);
    tick();
    csr_we_i = 1'b0;
    csr_wdata_i = '0;
  endtask

  task automatic pulse_sync(int m);
    sync_i = 2'(m);
    tick();
    sync_i = '0;
  endtask

  task automatic pulse_adv(int m);
    adv_i = 4'(m);
    tick();
    adv_i = '0;
  endtask

  // Write one entry and check the error flag against the layout model.
  task automatic wr_check(int a, logic [DW-1:0] d);
    bit blk;
    blk = is_act(a);
    tbl_we_i = 1'b1;
    tbl_addr_i = AW'(a);
    tbl_wdata_i = d;
    tick();
    tbl_we_i = 1'b0;
    chk("R5 write error flag", int'(wr_err_o), int'(blk));
    if (!blk) begin
      mdl[a] = d;
      known[a] = 1'b1;
    end
    if (blk) csr(4);
  endtask

  task automatic read_all();
    for (int a = 0; a < DEPTH; a++) begin
      tbl_addr_i = AW'(a);
      tick();
      if (known[a]) chk("R4 host readback", int'(tbl_rdata_o), int'(mdl[a]));
    end
  endtask

  task automatic swap(int t);
    csr(1 << t);
    chk("R7 request pending", int'(swap_pend_o[t]), 1);
    pulse_sync(1 << t);
    half_m[t] = ~half_m[t];
    chk("R7 half toggled", int'(active_half_o[t]), int'(half_m[t]));
    chk("R7 request cleared", int'(swap_pend_o[t]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; dual_i = 1'b0; sync_i = '0; adv_i = '0;
    tbl_we_i = 1'b0; tbl_addr_i = '0; tbl_wdata_i = '0;
    csr_we_i = 1'b0; csr_wdata_i = '0;
    dual_m = 0; half_m = '0;
    for (int a = 0; a < DEPTH; a++) known[a] = 0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R3 reset state, R1 single layout bases
    chk("R3 half", int'(active_half_o), 0);
    chk("R3 pending", int'(swap_pend_o), 0);
    chk("R3 error", int'(wr_err_o), 0);
    chk("R1 rx A base", raddr(0), 0);
    chk("R1 tx A base", raddr(2), 128);
    chk("R1 rx B idle", raddr(1), 0);
    chk("R1 tx B idle", raddr(3), 0);

    // R5 sweep in single layout, half 0 active
    for (int a = 0; a < DEPTH; a++) wr_check(a, dat(a, 0));

    // R8 sync without request
    pulse_sync(1);
    chk("R8 half held", int'(active_half_o[0]), 0);

    // R7 swap to half 1, R10 pointers rebased
    swap(0);
    chk("R10 rx A at new base", raddr(0), 64);
    chk("R10 tx A at new base", raddr(2), 192);

    for (int a = 0; a < DEPTH; a++) wr_check(a, dat(a, 1));
    read_all();

    // R9 full-region walk with wrap at region end
    for (int k = 1; k <= 64; k++) begin
      pulse_adv(1);
      chk("R9 rx A walk", raddr(0), 64 + (k % 64));
      chk("R9 rx A entry", rent(0), int'(mdl[64 + (k % 64)]));
    end

    // R9 last flag: shadow entry 5 marked last, then swap to half 0
    wr_check(5, dat(5, 1) | 8'h01);
    swap(0);
    chk("R10 rx A base after swap", raddr(0), 0);
    for (int k = 1; k <= 5; k++) pulse_adv(1);
    chk("R9 reached flagged entry", raddr(0), 5);
    pulse_adv(1);
    chk("R9 wrap on last flag", raddr(0), 0);
    pulse_adv(1);
    pulse_adv(1);
    sync_i = 2'b01; adv_i = 4'b0001;
    tick();
    sync_i = '0; adv_i = '0;
    chk("R10 sync beats advance", raddr(0), 0);

    // R1 / R7 request bit for TDM B ignored in single layout
    csr(2);
    chk("R7 B request ignored", int'(swap_pend_o[1]), 0);
    pulse_sync(2);
    chk("R1 B half stays 0", int'(active_half_o[1]), 0);

    // R6 sticky error and clear priority
    tbl_we_i = 1'b1; tbl_addr_i = 8'd10; tbl_wdata_i = 8'hAA;
    tick();
    tbl_we_i = 1'b0;
    tick(); tick();
    chk("R6 error sticky", int'(wr_err_o), 1);
    csr(4);
    chk("R6 error cleared", int'(wr_err_o), 0);
    tbl_we_i = 1'b1; csr_we_i = 1'b1; csr_wdata_i = 3'd4;
    tick();
    tbl_we_i = 1'b0; csr_we_i = 1'b0; csr_wdata_i = '0;
    chk("R6 set beats clear", int'(wr_err_o), 1);
    csr(4);

    // R11 layout change: pending cleared, concurrent write dropped
    csr(1);
    dual_i = 1'b1;
    tbl_we_i = 1'b1; tbl_addr_i = 8'd70; tbl_wdata_i = 8'h55;
    tick();
    tbl_we_i = 1'b0;
    dual_m = 1; half_m = '0;
    chk("R11 half reset", int'(active_half_o), 0);
    chk("R11 pending cleared", int'(swap_pend_o), 0);
    chk("R11 no error on drop", int'(wr_err_o), 0);
    tbl_addr_i = 8'd70;
    tick();
    chk("R11 write dropped", int'(tbl_rdata_o), int'(mdl[70]));

    // R2 dual layout bases
    chk("R2 rx A base", raddr(0), 0);
    chk("R2 rx B base", raddr(1), 64);
    chk("R2 tx A base", raddr(2), 128);
    chk("R2 tx B base", raddr(3), 192);
    swap(1);
    chk("R2 rx B swapped", raddr(1), 96);
    chk("R2 tx B swapped", raddr(3), 224);
    chk("R2 rx A untouched", raddr(0), 0);

    for (int a = 0; a < DEPTH; a++) wr_check(a, dat(a, 2));
    read_all();

    // R9 dual region walk for tx B
    for (int k = 1; k <= 32; k++) begin
      pulse_adv(8);
      chk("R9 tx B walk", raddr(3), 224 + (k % 32));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule